// File: doc/BRIEF.md
# Low-Frequency Clock Source Controller

This block holds the 32-bit control word of a low-frequency clock domain. Software reaches it over a simple write port with an always-valid read word. The word picks the slow clock source, either the internal RC-derived clock or an external 32.768 kHz crystal. It also picks the timer clock source, either that slow clock or a divided-down 24 MHz clock. Further fields set the crystal enable and a 2-bit crystal drive-strength code.

The two source-select bits are guarded. They change only when the upper half of the same write carries the key 0x16AA. A supervisor watches a clock-present input from the external crystal, synchronized into the bus clock domain. If no rising edge arrives within a set number of bus cycles, the supervisor declares the crystal lost. When automatic fallback is armed, hardware then clears the external-select bit so that the domain returns to the RC source.

Two busy flags show that a write to the day register or to the time-of-day register is still waiting to be applied. Each write completes on the next one-second tick.

Top module: `lfclk_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00004010, `xtal_en` is 1, `lo_src_ext`, `tmr_src_div` and `xtal_drive` are 0, and `ext_lost` is 0.
- R2: `lo_src_ext` mirrors bit 0 (0 = internal RC clock, 1 = external crystal). `tmr_src_div` mirrors bit 1 (0 = slow clock, 1 = divided 24 MHz clock). `xtal_drive` mirrors bits 3:2 (0 = low, 3 = high) and `xtal_en` mirrors bit 4.
- R3: A write whose bits 31:16 differ from 0x16AA leaves bits 1:0 unchanged while still updating bits 3:2, 4, 14 and 15.
- R4: A write whose bits 31:16 equal 0x16AA loads bits 1:0 from the written data, visible from the cycle after the write.
- R5: Bits 31:16, 13:9 and 6:5 always read 0, and a bus write cannot set bits 7 or 8.
- R6: Bit 14 = 1 arms fallback and bit 15 = 0 enables it. While both hold and `ext_lost` is 1, bit 0 is cleared on the next clock edge.
- R7: With bit 15 = 1 or bit 14 = 0, a loss of the external clock leaves bit 0 unchanged.
- R8: `ext_lost` rises after LOSS_TIMEOUT bus cycles pass with no synchronized rising edge of `ext_clk_in`, and falls again after edges return.
- R9: Bit 7 reads 1 from the cycle after a `day_wr` pulse until the cycle after the next `sec_tick`, when it reads 0.
- R10: Bit 8 behaves the same way for `hms_wr`.
- R11: When a keyed write sets bit 0 in the same cycle as a fallback clear, bit 0 ends at 0.
- R12: When a `day_wr` pulse and a `sec_tick` fall in the same cycle, bit 7 reads 1 afterwards and clears only on a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data, key in bits 31:16 |
| rd_data | output | 32 | Current control word |
| ext_clk_in | input | 1 | Clock-present signal of the external crystal, asynchronous |
| day_wr | input | 1 | Pulse: day register was written |
| hms_wr | input | 1 | Pulse: time-of-day register was written |
| sec_tick | input | 1 | One-second tick that applies pending writes |
| lo_src_ext | output | 1 | Slow clock source select |
| tmr_src_div | output | 1 | Timer clock source select |
| xtal_drive | output | 2 | Crystal drive-strength code |
| xtal_en | output | 1 | External crystal enable |
| ext_lost | output | 1 | External clock declared lost |

## Verification
The bench aims at the key check. A design that compares only part of the key, or that drops the whole write when the key is wrong, would either move the source bits or fail to update the drive and enable fields. It stops the crystal toggle for longer than the timeout to check both the fallback clear and its suppression through bit 15. A design with the polarity of bit 15 inverted would clear a source it should keep. It also writes the external select while the loss is still asserted: a design that lets the bus win would switch the domain back onto a dead clock. Finally, it places a busy-flag write on the same cycle as the tick, where a design that lets the tick win would report a pending write as already applied.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned KEY_W       = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h16AA;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_4010;

  localparam int unsigned B_LO_SRC   = 0;
  localparam int unsigned B_TMR_SRC  = 1;
  localparam int unsigned B_DRV_LO   = 2;
  localparam int unsigned B_DRV_HI   = 3;
  localparam int unsigned B_XTAL_EN  = 4;
  localparam int unsigned B_DAY_BSY  = 7;
  localparam int unsigned B_HMS_BSY  = 8;
  localparam int unsigned B_FB_ARM   = 14;
  localparam int unsigned B_FB_OFF_N = 15;

  localparam int unsigned N_BUSY     = 2;
  localparam int unsigned IDX_DAY    = 0;
  localparam int unsigned IDX_HMS    = 1;

  typedef struct packed {
    logic       fb_off;
    logic       fb_arm;
    logic       xtal_en;
    logic [1:0] drive;
    logic       tmr_src;
    logic       lo_src;
  } ctrl_fields_t;
endpackage

// File: rtl/lfc_loss_detect.sv
module lfc_loss_detect #(
  parameter int unsigned TIMEOUT     = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_in,
  output logic lost
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [SYNC_STAGES:0] shift_q;
  logic [CNT_W-1:0]     quiet_q;
  logic                 rise;
  logic                 lost_q;

  // last stage is the delayed copy used for edge detection
  assign rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      quiet_q <= '0;
      lost_q  <= 1'b0;
    end else begin
      shift_q <= {shift_q[SYNC_STAGES-1:0], clk_in};
      if (rise) begin
        quiet_q <= '0;
        lost_q  <= 1'b0;
      end else if (quiet_q != LIMIT) begin
        quiet_q <= quiet_q + 1'b1;
        lost_q  <= (quiet_q == LIMIT - 1'b1);
      end
    end
  end

  assign lost = lost_q;
endmodule

// File: rtl/lfc_busy_flag.sv
module lfc_busy_flag (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic tick,
  output logic busy
);
  logic busy_q;

  // a new request outranks the tick in the same cycle
  always_ff @(posedge clk) begin
    if (rst)       busy_q <= 1'b0;
    else if (req)  busy_q <= 1'b1;
    else if (tick) busy_q <= 1'b0;
  end

  assign busy = busy_q;
endmodule

// File: rtl/lfc_ctrl_reg.sv
module lfc_ctrl_reg
  import lfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lost,
  output ctrl_fields_t      fields
);
  ctrl_fields_t f_q;
  logic         key_ok;
  logic         hw_clear;

  assign key_ok   = (wr_data[WORD_W-1 -: KEY_W] == UNLOCK_KEY);
  assign hw_clear = lost & f_q.fb_arm & ~f_q.fb_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q.lo_src  <= RESET_WORD[B_LO_SRC];
      f_q.tmr_src <= RESET_WORD[B_TMR_SRC];
      f_q.drive   <= RESET_WORD[B_DRV_HI:B_DRV_LO];
      f_q.xtal_en <= RESET_WORD[B_XTAL_EN];
      f_q.fb_arm  <= RESET_WORD[B_FB_ARM];
      f_q.fb_off  <= RESET_WORD[B_FB_OFF_N];
    end else begin
      if (wr_en) begin
        f_q.drive   <= wr_data[B_DRV_HI:B_DRV_LO];
        f_q.xtal_en <= wr_data[B_XTAL_EN];
        f_q.fb_arm  <= wr_data[B_FB_ARM];
        f_q.fb_off  <= wr_data[B_FB_OFF_N];
        if (key_ok) f_q.tmr_src <= wr_data[B_TMR_SRC];
      end
      if (hw_clear)
        f_q.lo_src <= 1'b0;
      else if (wr_en && key_ok)
        f_q.lo_src <= wr_data[B_LO_SRC];
    end
  end

  assign fields = f_q;
endmodule

// File: rtl/lfclk_ctrl.sv
module lfclk_ctrl
  import lfc_pkg::*;
#(
  parameter int unsigned LOSS_TIMEOUT = 256,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        ext_clk_in,
  input  logic        day_wr,
  input  logic        hms_wr,
  input  logic        sec_tick,
  output logic        lo_src_ext,
  output logic        tmr_src_div,
  output logic [1:0]  xtal_drive,
  output logic        xtal_en,
  output logic        ext_lost
);
  ctrl_fields_t     fields;
  logic [N_BUSY-1:0] busy_req;
  logic [N_BUSY-1:0] busy;
  logic              lost;

  lfc_loss_detect #(
    .TIMEOUT     (LOSS_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_loss (
    .clk    (clk),
    .rst    (rst),
    .clk_in (ext_clk_in),
    .lost   (lost)
  );

  lfc_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lost    (lost),
    .fields  (fields)
  );

  assign busy_req[IDX_DAY] = day_wr;
  assign busy_req[IDX_HMS] = hms_wr;

  for (genvar g = 0; g < N_BUSY; g++) begin : g_busy
    lfc_busy_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .req  (busy_req[g]),
      .tick (sec_tick),
      .busy (busy[g])
    );
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[B_LO_SRC]             = fields.lo_src;
    rd_data[B_TMR_SRC]            = fields.tmr_src;
    rd_data[B_DRV_HI:B_DRV_LO]    = fields.drive;
    rd_data[B_XTAL_EN]            = fields.xtal_en;
    rd_data[B_DAY_BSY]            = busy[IDX_DAY];
    rd_data[B_HMS_BSY]            = busy[IDX_HMS];
    rd_data[B_FB_ARM]             = fields.fb_arm;
    rd_data[B_FB_OFF_N]           = fields.fb_off;
  end

  assign lo_src_ext  = fields.lo_src;
  assign tmr_src_div = fields.tmr_src;
  assign xtal_drive  = fields.drive;
  assign xtal_en     = fields.xtal_en;
  assign ext_lost    = lost;
endmodule

// File: rtl/lfc_chk.sv
module lfc_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        day_wr,
  input logic        hms_wr,
  input logic        sec_tick,
  input logic        lo_src_ext,
  input logic        tmr_src_div,
  input logic        ext_lost
);
  // R3: without the key the timer select cannot move
  a_r3_keyless_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_data[31:16] != 16'h16AA) |=> $stable(tmr_src_div));

  // R4: keyed write with no fallback clear loads the slow source select
  a_r4_key_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:16] == 16'h16AA && !(ext_lost && rd_data[14] && !rd_data[15]))
    |=> (lo_src_ext == $past(wr_data[0])));

  // R6 and R11: an armed fallback during loss forces the internal source
  a_r6_fallback: assert property (@(posedge clk) disable iff (rst)
    (ext_lost && rd_data[14] && !rd_data[15]) |=> !lo_src_ext);

  // R9: day busy flag set and cleared
  a_r9_day_set: assert property (@(posedge clk) disable iff (rst)
    day_wr |=> rd_data[7]);
  a_r9_day_clear: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !day_wr) |=> !rd_data[7]);

  // R10: time-of-day busy flag set and cleared
  a_r10_hms_set: assert property (@(posedge clk) disable iff (rst)
    hms_wr |=> rd_data[8]);
  a_r10_hms_clear: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !hms_wr) |=> !rd_data[8]);
endmodule

bind lfclk_ctrl lfc_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .day_wr      (day_wr),
  .hms_wr      (hms_wr),
  .sec_tick    (sec_tick),
  .lo_src_ext  (lo_src_ext),
  .tmr_src_div (tmr_src_div),
  .ext_lost    (ext_lost)
);

// File: tb/sim_lfclk_ctrl.sv
`timescale 1ns/1ps
module sim_lfclk_ctrl;
  localparam int TMO = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ext_clk_in = 1'b0;
  logic        day_wr = 1'b0;
  logic        hms_wr = 1'b0;
  logic        sec_tick = 1'b0;
  logic        lo_src_ext, tmr_src_div, xtal_en, ext_lost;
  logic [1:0]  xtal_drive;

  int checks = 0;
  int errors = 0;
  bit ext_run = 1'b1;
  bit done = 1'b0;
  int ext_cnt = 0;

  always #4 clk = ~clk;

  lfclk_ctrl #(.LOSS_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_clk_in(ext_clk_in), .day_wr(day_wr), .hms_wr(hms_wr), .sec_tick(sec_tick),
    .lo_src_ext(lo_src_ext), .tmr_src_div(tmr_src_div), .xtal_drive(xtal_drive),
    .xtal_en(xtal_en), .ext_lost(ext_lost)
  );

  // external crystal model: toggles every 8 bus cycles while running
  initial forever begin
    @(negedge clk);
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt == 8) begin
        ext_cnt = 0;
        ext_clk_in = ~ext_clk_in;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input bit d, input bit h, input bit t);
    @(negedge clk);
    day_wr = d; hms_wr = h; sec_tick = t;
    @(negedge clk);
    day_wr = 1'b0; hms_wr = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 word", rd_data, 32'h0000_4010);
    check("R1 xtal_en", {31'd0, xtal_en}, 32'd1);
    check("R1 lost", {31'd0, ext_lost}, 32'd0);
  endtask

  task automatic t_key;
    bus_write(32'h16AA_4013);
    check("R4 keyed word", rd_data, 32'h0000_4013);
    check("R2 pins", {27'd0, xtal_en, xtal_drive, tmr_src_div, lo_src_ext}, 32'h13);
    bus_write(32'h16AB_000C);
    check("R3 wrong key", rd_data, 32'h0000_000F);
    bus_write(32'h0000_4010);
    check("R3 no key", rd_data, 32'h0000_4013);
    bus_write(32'h16AA_4010);
    check("R4 keyed clear", rd_data, 32'h0000_4010);
  endtask

  task automatic t_reserved;
    bus_write(32'h16AA_FFFF);
    check("R5 reserved", rd_data, 32'h0000_C01F);
    bus_write(32'h16AA_4010);
    check("R5 restore", rd_data, 32'h0000_4010);
  endtask

  task automatic t_fallback;
    bus_write(32'h16AA_4011);
    check("R4 select ext", {31'd0, lo_src_ext}, 32'd1);
    ext_run = 1'b0;
    idle(TMO / 2);
    check("R8 not yet lost", {31'd0, ext_lost}, 32'd0);
    idle(TMO / 2 + 20);
    check("R8 lost", {31'd0, ext_lost}, 32'd1);
    check("R6 cleared", {31'd0, lo_src_ext}, 32'd0);
    bus_write(32'h16AA_4011);
    check("R11 hw wins", {31'd0, lo_src_ext}, 32'd0);
    ext_run = 1'b1;
    idle(40);
    check("R8 recovered", {31'd0, ext_lost}, 32'd0);
  endtask

  task automatic t_no_fallback;
    bus_write(32'h16AA_C011);
    ext_run = 1'b0;
    idle(TMO + 20);
    check("R8 lost again", {31'd0, ext_lost}, 32'd1);
    check("R7 bit15 keeps", {31'd0, lo_src_ext}, 32'd1);
    bus_write(32'h0000_0010);
    idle(2);
    check("R7 bit14 low keeps", {31'd0, lo_src_ext}, 32'd1);
    ext_run = 1'b1;
    idle(40);
    bus_write(32'h16AA_4010);
    check("R4 back to rc", rd_data, 32'h0000_4010);
  endtask

  task automatic t_busy;
    pulse(1'b1, 1'b0, 1'b0);
    check("R9 day set", {31'd0, rd_data[7]}, 32'd1);
    idle(5);
    check("R9 day held", {31'd0, rd_data[7]}, 32'd1);
    pulse(1'b0, 1'b0, 1'b1);
    check("R9 day clear", {31'd0, rd_data[7]}, 32'd0);
    pulse(1'b0, 1'b1, 1'b0);
    check("R10 hms set", {31'd0, rd_data[8]}, 32'd1);
    pulse(1'b0, 1'b0, 1'b1);
    check("R10 hms clear", {31'd0, rd_data[8]}, 32'd0);
    pulse(1'b1, 1'b0, 1'b1);
    check("R12 same cycle", {31'd0, rd_data[7]}, 32'd1);
    pulse(1'b0, 1'b0, 1'b1);
    check("R12 later tick", {31'd0, rd_data[7]}, 32'd0);
    bus_write(32'h16AA_4190);
    check("R5 busy not writable", rd_data, 32'h0000_4010);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_key();
    t_reserved();
    t_fallback();
    t_no_fallback();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule